// File: doc/BRIEF.md
# Error-Correcting Word Store with Maintenance Modes

The block is a small synchronous memory. It holds 64-bit words and keeps an 8-bit single-error-correcting, double-error-detecting code beside each one. On a normal write it computes the code. On a normal read it recomputes the code and forms a syndrome. A single flipped bit is repaired and flagged as correctable. A double flip is flagged as uncorrectable, and the data comes back unchanged.

A 6-bit maintenance control word changes this behaviour for test. Its two-bit mode field can do three things in place of the normal path:
- load the stored check bits straight from chosen data-in bits,
- return the stored check bits on chosen data-out bits,
- return the syndrome of the word being read on those same data-out bits.

Further control bits do the following:
- turn off correction and error flagging,
- turn off the byte-parity check on write data,
- make the generated read parity even instead of odd,
- keep correctable errors out of the error log.

The error log keeps the first logged error until software clears it.

Reads are registered: the result appears with `rd_valid` one clock after the request. A control write is used from the next access onward. `rst_n` is asynchronous and active low. It must be released in step with `clk` by the surrounding reset logic.

Top module: `secded_diag_mem`

## Requirements
- R1: The code is formed from the 64 data bits and 8 check bits as follows. Data bits, in ascending order, take codeword positions 1 to 71, skipping the powers of two. Check bit i (i = 0 to 6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all data bits and check bits 0 to 6. In mode 00 a write stores this code, and a read of an intact word returns the data with `rd_ce` and `rd_ue` low.
- R2: The syndrome is formed in two parts. Bits 6:0 are the stored check bits 6:0 XOR the check bits recomputed from the stored data. Bit 7 is the XOR of all stored data and all 8 stored check bits. If the syndrome is nonzero and bit 7 is 1, the read raises `rd_ce`; when bits 6:0 equal the position of a data bit, that data bit is inverted on return. If the syndrome is nonzero and bit 7 is 0, the read raises `rd_ue` and the data is returned uncorrected. `rd_ce` and `rd_ue` are never high together.
- R3: `ctl_wdata[1:0]` is the mode field. In mode 01, a write stores the data as given. Its check bits 0 to 7 are taken from data-in bits 0, 1, 4, 5, 8, 9, 12, 13, in that order.
- R4: In mode 10, a read places stored check bit k on data-out bit 4*(k/2)+(k%2). All other data-out bits are 0.
- R5: In mode 11, a read places syndrome bit k on the same data-out positions as in R4. All other data-out bits are 0.
- R6: When `ctl_wdata[2]` is set, reads return the stored data uncorrected, `rd_ce` and `rd_ue` stay low, and nothing is logged.
- R7: `req_wpar[b]` is odd parity for write byte b: the byte and its parity bit together hold an odd number of ones. A mismatch on any byte raises `wpar_err` in the cycle after the write. `ctl_wdata[3]` suppresses this flag.
- R8: `rd_par[b]` is odd parity over `rd_data` byte b. When `ctl_wdata[4]` is set, it is even parity instead.
- R9: The first logged error captures its address, its syndrome and whether it was uncorrectable, and sets `log_valid`. These values hold until `log_clr` is pulsed. A clear takes priority over a capture in the same cycle.
- R10: When `ctl_wdata[5]` is set, correctable errors are not logged. Uncorrectable errors still are.
- R11: A read's result and `rd_valid` appear one clock after the request. A control write applies from the next access, so an access in the same cycle uses the previous setting.
- R12: After reset, `rd_valid`, `wpar_err` and `log_valid` are low and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_wpar | input | 8 | Odd parity per write byte |
| ctl_we | input | 1 | Load control word |
| ctl_wdata | input | 6 | Control word: mode[1:0], no-correct, no-parity-check, even parity, no-correctable-log |
| log_clr | input | 1 | Clear error log |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read data or diagnostic pattern |
| rd_par | output | 8 | Generated parity per read byte |
| rd_ce | output | 1 | Correctable error on this read |
| rd_ue | output | 1 | Uncorrectable error on this read |
| wpar_err | output | 1 | Write data parity mismatch |
| log_valid | output | 1 | Log holds an error |
| log_addr | output | ADDR_W | Logged word address |
| log_syn | output | 8 | Logged syndrome |
| log_ue | output | 1 | Logged error was uncorrectable |

## Verification
The check bits are only visible through the diagnostic modes, so a fault in them stays hidden on plain reads. A wrong encoder or a wrong bit routing shows up on the first read in mode 10 or 11 as a mismatched scattered pattern, one clock after the request. A wrong syndrome or correction mask shows up at once as wrong data or a wrong error flag when unit and random words are stored through mode 01. A wrong capture rule or hold rule in the error log shows on `log_*` one clock after the offending read.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CW_TOP = DATA_W + HAM_W;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  chk_t;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_CHK_IN  = 2'b01,
    MODE_CHK_OUT = 2'b10,
    MODE_SYN_OUT = 2'b11
  } diag_mode_e;

  // Field order sets the control-word bit positions: mode sits in [1:0].
  typedef struct packed {
    logic       no_ce_log;
    logic       even_par;
    logic       no_par_chk;
    logic       no_correct;
    diag_mode_e mode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming part of the code: XOR of the positions of all set data bits.
  function automatic logic [HAM_W-1:0] ham_bits(word_t d);
    logic [HAM_W-1:0] h;
    int di;
    h  = '0;
    di = 0;
    for (int p = 1; p <= CW_TOP; p++) begin
      if (!is_pow2(p)) begin
        if (d[di[IDX_W-1:0]]) h ^= HAM_W'(p);
        di++;
      end
    end
    return h;
  endfunction

  // One-hot mask of the data bit sitting at codeword position s (zero if none).
  function automatic word_t flip_mask(logic [HAM_W-1:0] s);
    word_t m;
    int di;
    m  = '0;
    di = 0;
    for (int p = 1; p <= CW_TOP; p++) begin
      if (!is_pow2(p)) begin
        if (s == HAM_W'(p)) m[di[IDX_W-1:0]] = 1'b1;
        di++;
      end
    end
    return m;
  endfunction

  // Diagnostic routing: item k travels on data bit 4*(k/2)+(k%2).
  function automatic logic [IDX_W-1:0] route_pos(int k);
    return IDX_W'(4 * (k / 2) + (k % 2));
  endfunction

  function automatic word_t spread_chk(chk_t v);
    word_t w;
    w = '0;
    for (int k = 0; k < CHK_W; k++) w[route_pos(k)] = v[k];
    return w;
  endfunction

  function automatic chk_t pick_chk(word_t w);
    chk_t v;
    for (int k = 0; k < CHK_W; k++) v[k] = w[route_pos(k)];
    return v;
  endfunction

  localparam word_t ROUTE_MASK = spread_chk('1);

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  word_t enc_data,
  output chk_t  enc_chk
);

  logic [HAM_W-1:0] ham;

  always_comb begin
    ham     = ham_bits(enc_data);
    enc_chk = {(^enc_data) ^ (^ham), ham};
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  word_t raw_data,
  input  chk_t  raw_chk,
  output chk_t  syn,
  output logic  err_ce,
  output logic  err_ue,
  output word_t fixed_data
);

  logic nz;

  always_comb begin
    syn[HAM_W-1:0] = raw_chk[HAM_W-1:0] ^ ham_bits(raw_data);
    syn[CHK_W-1]   = (^raw_data) ^ (^raw_chk);
    nz             = |syn;
    err_ce         = nz & syn[CHK_W-1];
    err_ue         = nz & ~syn[CHK_W-1];
    fixed_data     = raw_data;
    if (err_ce) fixed_data = raw_data ^ flip_mask(syn[HAM_W-1:0]);
  end

endmodule

// File: rtl/byte_par.sv
module byte_par #(
  parameter int NB = 8,
  parameter int BW = 8
) (
  input  logic [NB*BW-1:0] par_data,
  input  logic             even_sel,
  output logic [NB-1:0]    par_out
);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par_out[b] = (^par_data[b*BW +: BW]) ^ ~even_sel;
  end

endmodule

// File: rtl/err_log.sv
module err_log #(
  parameter int AW = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_ue,
  input  logic [AW-1:0] cap_addr,
  input  logic [SW-1:0] cap_syn,
  input  logic          clr,
  output logic          log_valid,
  output logic [AW-1:0] log_addr,
  output logic [SW-1:0] log_syn,
  output logic          log_ue
);

  logic          valid_q, valid_n;
  logic          ue_q, ue_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [SW-1:0] syn_q, syn_n;

  always_comb begin
    valid_n = valid_q;
    ue_n    = ue_q;
    addr_n  = addr_q;
    syn_n   = syn_q;
    if (clr) begin
      valid_n = 1'b0;
    end else if (cap_en && !valid_q) begin
      valid_n = 1'b1;
      ue_n    = cap_ue;
      addr_n  = cap_addr;
      syn_n   = cap_syn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ue_q    <= 1'b0;
      addr_q  <= '0;
      syn_q   <= '0;
    end else begin
      valid_q <= valid_n;
      ue_q    <= ue_n;
      addr_q  <= addr_n;
      syn_q   <= syn_n;
    end
  end

  assign log_valid = valid_q;
  assign log_ue    = ue_q;
  assign log_addr  = addr_q;
  assign log_syn   = syn_q;

  p_log_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !clr) |=> (log_valid && $stable(log_addr) && $stable(log_syn) && $stable(log_ue)));

  p_log_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !log_valid);

endmodule

// File: rtl/secded_diag_mem.sv
module secded_diag_mem
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_wpar,
  input  logic              ctl_we,
  input  logic [5:0]        ctl_wdata,
  input  logic              log_clr,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic [7:0]        rd_par,
  output logic              rd_ce,
  output logic              rd_ue,
  output logic              wpar_err,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr,
  output logic [7:0]        log_syn,
  output logic              log_ue
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = DATA_W + CHK_W;

  ctl_t ctl_q, ctl_n;
  logic [ROW_W-1:0] mem_q [DEPTH];

  logic  wr_en, rd_en;
  chk_t  enc_chk, chk_store;
  logic [ROW_W-1:0] row;
  word_t raw_data, fixed_data, rd_data_n;
  chk_t  raw_chk, syn;
  logic  dec_ce, dec_ue, ce_n, ue_n, log_cap;
  logic [NBYTES-1:0] rd_par_n, wpar_exp;
  logic  wpar_err_n;

  logic        rd_valid_q;
  word_t       rd_data_q;
  logic [7:0]  rd_par_q;
  logic        rd_ce_q, rd_ue_q, wpar_err_q;

  // Control register
  always_comb begin
    ctl_n = ctl_q;
    if (ctl_we) ctl_n = ctl_t'(ctl_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_n;
  end

  // Write path
  assign wr_en = req_valid & req_we;
  assign rd_en = req_valid & ~req_we;

  secded_enc u_enc (
    .enc_data (req_wdata),
    .enc_chk  (enc_chk)
  );

  byte_par #(.NB(NBYTES), .BW(BYTE_W)) u_wpar (
    .par_data (req_wdata),
    .even_sel (1'b0),
    .par_out  (wpar_exp)
  );

  always_comb begin
    chk_store  = (ctl_q.mode == MODE_CHK_IN) ? pick_chk(req_wdata) : enc_chk;
    wpar_err_n = wr_en & ~ctl_q.no_par_chk & (|(wpar_exp ^ req_wpar));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[req_addr] <= {chk_store, req_wdata};
  end

  // Read path
  assign row      = mem_q[req_addr];
  assign raw_data = row[DATA_W-1:0];
  assign raw_chk  = row[ROW_W-1:DATA_W];

  secded_dec u_dec (
    .raw_data   (raw_data),
    .raw_chk    (raw_chk),
    .syn        (syn),
    .err_ce     (dec_ce),
    .err_ue     (dec_ue),
    .fixed_data (fixed_data)
  );

  always_comb begin
    unique case (ctl_q.mode)
      MODE_CHK_OUT: rd_data_n = spread_chk(raw_chk);
      MODE_SYN_OUT: rd_data_n = spread_chk(syn);
      default:      rd_data_n = ctl_q.no_correct ? raw_data : fixed_data;
    endcase
    ce_n    = dec_ce & ~ctl_q.no_correct;
    ue_n    = dec_ue & ~ctl_q.no_correct;
    log_cap = rd_en & (ue_n | (ce_n & ~ctl_q.no_ce_log));
  end

  byte_par #(.NB(NBYTES), .BW(BYTE_W)) u_rpar (
    .par_data (rd_data_n),
    .even_sel (ctl_q.even_par),
    .par_out  (rd_par_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_ce_q    <= 1'b0;
      rd_ue_q    <= 1'b0;
      wpar_err_q <= 1'b0;
      rd_data_q  <= '0;
      rd_par_q   <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_ce_q    <= rd_en & ce_n;
      rd_ue_q    <= rd_en & ue_n;
      wpar_err_q <= wpar_err_n;
      if (rd_en) begin
        rd_data_q <= rd_data_n;
        rd_par_q  <= rd_par_n;
      end
    end
  end

  err_log #(.AW(ADDR_W), .SW(CHK_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (log_cap),
    .cap_ue    (ue_n),
    .cap_addr  (req_addr),
    .cap_syn   (syn),
    .clr       (log_clr),
    .log_valid (log_valid),
    .log_addr  (log_addr),
    .log_syn   (log_syn),
    .log_ue    (log_ue)
  );

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_par   = rd_par_q;
  assign rd_ce    = rd_ce_q;
  assign rd_ue    = rd_ue_q;
  assign wpar_err = wpar_err_q;

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);

  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rd_valid);

  p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ce && rd_ue));

  // R4 and R5: diagnostic reads drive nothing outside the routed bits
  p_diag_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(ctl_q.mode[1])) |-> ((rd_data & ~ROUTE_MASK) == '0));

  p_raw_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(ctl_q.no_correct)) |-> (!rd_ce && !rd_ue));

  p_parchk_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wpar_err |-> $past(req_valid && req_we && !ctl_q.no_par_chk));

endmodule

// File: tb/secded_diag_mem_tb_top.sv
module secded_diag_mem_tb_top;

  localparam int AW = 4;

  logic          clk, rst_n;
  logic          req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [63:0]   req_wdata;
  logic [7:0]    req_wpar;
  logic          ctl_we;
  logic [5:0]    ctl_wdata;
  logic          log_clr;
  logic          rd_valid, rd_ce, rd_ue, wpar_err, log_valid, log_ue;
  logic [63:0]   rd_data;
  logic [7:0]    rd_par, log_syn;
  logic [AW-1:0] log_addr;

  secded_diag_mem #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wpar(req_wpar),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .log_clr(log_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
    .rd_ce(rd_ce), .rd_ue(rd_ue), .wpar_err(wpar_err),
    .log_valid(log_valid), .log_addr(log_addr), .log_syn(log_syn), .log_ue(log_ue)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit cur_even = 0;
  int dpos[64];
  logic [63:0] rs = 64'h0123_4567_89AB_CDEF;

  // ---------------- reference model, from the requirements ----------------
  function automatic logic [6:0] m_ham(logic [63:0] d);
    logic [6:0] h = '0;
    for (int j = 0; j < 64; j++) if (d[j]) h ^= dpos[j][6:0];
    return h;
  endfunction

  function automatic logic [7:0] m_chk(logic [63:0] d);
    logic [6:0] h = m_ham(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [63:0] m_spread(logic [7:0] v);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++) w[4*(k/2)+(k%2)] = v[k];
    return w;
  endfunction

  function automatic logic [7:0] m_pick(logic [63:0] w);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = w[4*(k/2)+(k%2)];
    return v;
  endfunction

  function automatic logic [7:0] m_syn(logic [63:0] w, logic [7:0] c);
    return {(^w) ^ (^c), c[6:0] ^ m_ham(w)};
  endfunction

  function automatic logic [63:0] m_fix(logic [63:0] w, logic [7:0] s);
    logic [63:0] r = w;
    if (s != 0 && s[7])
      for (int j = 0; j < 64; j++) if (dpos[j] == int'(s[6:0])) r[j] = ~r[j];
    return r;
  endfunction

  function automatic logic [7:0] m_par(logic [63:0] d, bit even);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = (^d[8*b +: 8]) ^ ~even;
    return p;
  endfunction

  function automatic logic [63:0] pat(int a);
    return {32'(a) * 32'h9E37_79B9, ~(32'(a) * 32'h7F4A_7C15)};
  endfunction

  // ---------------- checks and drivers ----------------
  task automatic ck(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [63:0] d, logic [7:0] p);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d; req_wpar = p;
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic do_rd(logic [AW-1:0] a);
    req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic set_ctl(logic [5:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
    cur_even = v[4];
  endtask

  task automatic clr_log();
    log_clr = 1;
    @(negedge clk);
    log_clr = 0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [63:0] ed, logic ece, logic eue);
    do_rd(a);
    ck({tag, " valid"}, rd_valid, 1);
    ck({tag, " data"}, rd_data, ed);
    ck({tag, " flags"}, {rd_ce, rd_ue}, {ece, eue});
    ck({tag, " R8 parity"}, rd_par, m_par(ed, cur_even));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int p = 1;
    for (int j = 0; j < 64; j++) begin
      while ((p & (p - 1)) == 0) p++;
      dpos[j] = p;
      p++;
    end
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    req_wpar = '0; ctl_we = 0; ctl_wdata = '0; log_clr = 0;
    repeat (3) @(negedge clk);
    ck("R12 rd_valid", rd_valid, 0);
    ck("R12 wpar_err", wpar_err, 0);
    ck("R12 log_valid", log_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: normal writes and reads over every address
    for (int a = 0; a < 16; a++) begin
      do_wr(AW'(a), pat(a), m_par(pat(a), 0));
      ck("R7 good parity", wpar_err, 0);
    end
    for (int a = 0; a < 16; a++) rd_chk("R1", AW'(a), pat(a), 0, 0);

    // R4: stored check bits on routed positions; R5: clean syndrome is zero
    set_ctl(6'h02);
    for (int a = 0; a < 16; a++) begin
      do_rd(AW'(a));
      ck("R4 check bits out", rd_data, m_spread(m_chk(pat(a))));
    end
    set_ctl(6'h03);
    for (int a = 0; a < 16; a++) begin
      do_rd(AW'(a));
      ck("R5 clean syndrome", rd_data, 0);
    end

    // R11: control write in the same cycle as a read uses the old mode
    set_ctl(6'h00);
    ctl_we = 1; ctl_wdata = 6'h02;
    req_valid = 1; req_we = 0; req_addr = '0;
    @(negedge clk);
    ctl_we = 0; req_valid = 0;
    ck("R11 same-cycle old mode", rd_data, pat(0));
    do_rd('0);
    ck("R11 next access new mode", rd_data, m_spread(m_chk(pat(0))));

    // R2, R3, R5: words stored through mode 01, unit vectors then random
    for (int i = 0; i < 160; i++) begin
      logic [63:0] w;
      logic [7:0]  c, s;
      logic [AW-1:0] a;
      if (i < 64) w = 64'd1 << i;
      else begin
        rs ^= rs << 13; rs ^= rs >> 7; rs ^= rs << 17;
        w = rs;
      end
      a = AW'(i);
      c = m_pick(w);
      s = m_syn(w, c);
      set_ctl(6'h01);
      do_wr(a, w, m_par(w, 0));
      set_ctl(6'h00);
      rd_chk("R2", a, m_fix(w, s), (s != 0) && s[7], (s != 0) && !s[7]);
      set_ctl(6'h02);
      do_rd(a);
      ck("R3 injected check bits", rd_data, m_spread(c));
      set_ctl(6'h03);
      do_rd(a);
      ck("R5 syndrome out", rd_data, m_spread(s));
    end

    // R9 / R10: error log
    set_ctl(6'h00);
    clr_log();
    ck("R9 cleared", log_valid, 0);
    set_ctl(6'h01);
    do_wr(4'd3, 64'h4, m_par(64'h4, 0));
    do_wr(4'd5, 64'hC, m_par(64'hC, 0));
    set_ctl(6'h00);
    do_rd(4'd3);
    ck("R9 ce flag", rd_ce, 1);
    ck("R9 log valid", log_valid, 1);
    ck("R9 log addr", log_addr, 3);
    ck("R9 log syn", log_syn, m_syn(64'h4, m_pick(64'h4)));
    ck("R9 log ue", log_ue, 0);
    do_rd(4'd5);
    ck("R9 ue flag", rd_ue, 1);
    ck("R9 first kept", log_addr, 3);
    clr_log();
    ck("R9 clear", log_valid, 0);
    set_ctl(6'h20);
    do_rd(4'd3);
    ck("R10 ce not logged", log_valid, 0);
    do_rd(4'd5);
    ck("R10 ue logged", log_valid, 1);
    ck("R10 ue addr", log_addr, 5);
    ck("R10 ue kind", log_ue, 1);

    // R6: correction disabled
    clr_log();
    set_ctl(6'h04);
    rd_chk("R6 raw", 4'd3, 64'h4, 0, 0);
    rd_chk("R6 raw", 4'd5, 64'hC, 0, 0);
    ck("R6 nothing logged", log_valid, 0);

    // R7: write parity check
    set_ctl(6'h00);
    for (int b = 0; b < 8; b++) begin
      do_wr(4'd8, pat(8), m_par(pat(8), 0) ^ (8'd1 << b));
      ck("R7 bad parity flagged", wpar_err, 1);
    end
    set_ctl(6'h08);
    do_wr(4'd9, pat(9), ~m_par(pat(9), 0));
    ck("R7 check disabled", wpar_err, 0);
    set_ctl(6'h00);
    do_wr(4'd10, pat(10), m_par(pat(10), 0));
    ck("R7 good parity", wpar_err, 0);

    // R8: even parity on reads
    set_ctl(6'h10);
    rd_chk("R8 even", 4'd8, pat(8), 0, 0);
    rd_chk("R8 even", 4'd9, pat(9), 0, 0);
    rd_chk("R8 even", 4'd10, pat(10), 0, 0);
    set_ctl(6'h00);
    rd_chk("R8 odd", 4'd10, pat(10), 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule